// File: doc/BRIEF.md
# Disk Channel Address Window Decoder

This block sorts each incoming bus address into one of five programmable address windows that front a two-channel disk interface. There are four per-channel windows: a command window and a control window for each of the primary and secondary channels. The fifth window holds the bus-master registers, and both channels share it. For an address that hits a window, the block reports four things: the kind of window, which channel the access belongs to, the byte offset from the window's base, and a 2-bit drive index. The drive index combines the channel with a device-select bit kept for each channel. An address that falls in no window raises an error flag instead.

Each window is described by a base and a size held in registers. A small indexed configuration port writes these registers and reads them back, together with the two device-select bits. This lets system software move the windows and lets the full decoder state be saved and restored. The address comparison itself is combinational. The result is registered and marked by a valid strobe one cycle after the request.

Top module: `disk_port_decoder`

## Requirements
- R1: After reset, `rsp_valid` is 0, every window register reads back its parameter default (primary command 0x01F0/8, primary control 0x03F4/4, secondary command 0x0170/8, secondary control 0x0374/4, bus-master 0xF000/16), and the device-select register reads 0.
- R2: An address hits a window exactly when base <= addr < base + size. Both the first and the last byte hit. The byte just past the end misses, and so does the byte just below the base.
- R3: `rsp_type` is 1 for a command window hit, 2 for a control window hit, 3 for a bus-master window hit, and 0 when nothing hits.
- R4: `rsp_offset` equals the address minus the base of the window that hit.
- R5: In the bus-master window, `rsp_secondary` is 0 when the offset is below `BMI_SPLIT` (default 8) and 1 otherwise. For the other windows, `rsp_secondary` comes from the window itself.
- R6: An address that hits no window gives `rsp_err`=1, with `rsp_type`, `rsp_secondary`, `rsp_drive` and `rsp_offset` all 0.
- R7: When windows overlap, the first match wins, in this order: primary command, primary control, secondary command, secondary control, bus-master.
- R8: On a hit, `rsp_drive` = 2*`rsp_secondary` + that channel's device-select bit. Bit 0 of configuration index 10 is the primary channel's bit and bit 1 is the secondary channel's bit.
- R9: Configuration index 2*w holds the base of window w and index 2*w+1 holds its size, with w following the order in R7. Index 10 is the device-select register. Writes take effect on the next cycle. Indices 11 to 15 read 0, and writes to them change nothing.
- R10: `rsp_valid` is 1 exactly one cycle after each cycle in which `req_valid` is 1, and 0 otherwise. Back-to-back requests each produce one result, in order.
- R11: A window of size 0 matches nothing. The end of a window is computed without wrap-around, so a window that reaches the top of the address space does not match low addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | 4 | Configuration register index |
| cfg_wdata | input | ADDR_W | Configuration write data |
| cfg_rdata | output | ADDR_W | Configuration read data for `cfg_idx` (combinational) |
| req_valid | input | 1 | Decode request strobe |
| req_addr | input | ADDR_W | Address to decode |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_type | output | 2 | Window kind: 0 none, 1 command, 2 control, 3 bus-master |
| rsp_secondary | output | 1 | 1 when the access belongs to the secondary channel |
| rsp_offset | output | ADDR_W | Offset of the address from the base of the window that hit |
| rsp_err | output | 1 | No window matched |
| rsp_drive | output | 2 | Drive index: channel times two plus the device-select bit |

## Verification
The bench builds the decoder with its defaults: a 16-bit address, a bus-master split at offset 8, and the usual legacy window placement. With this setup, every window edge can be tested directly: base, base-1, the last byte and one past the end. The 16-bit space also lets the bench move the bus-master window to 0xFFF8 so that it runs past the top of the address space, which shows whether low addresses are wrongly matched by a wrapped end. Reprogramming the secondary command window onto the primary one, and then setting the primary command size to 0, exercises both the priority order and the disabled window.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
   // Window order is also the match priority order (lowest index wins)
   localparam int NUM_WIN    = 5;
   localparam int NUM_CHAN   = 2;
   localparam int WIN_BMI    = 4;
   localparam int CFG_DEV_IDX = 2 * NUM_WIN;
   localparam int CFG_IDX_W  = $clog2(CFG_DEV_IDX + 1);

   typedef enum logic [1:0] {
      KIND_NONE = 2'd0,
      KIND_CMD  = 2'd1,
      KIND_CTRL = 2'd2,
      KIND_BMI  = 2'd3
   } win_kind_e;

   function automatic win_kind_e kind_of(input int w);
      if (w == WIN_BMI) return KIND_BMI;
      return ((w % 2) == 0) ? KIND_CMD : KIND_CTRL;
   endfunction

   // Channel owning a per-channel window (0,1 primary; 2,3 secondary)
   function automatic logic chan_of(input int w);
      return (w >= 2);
   endfunction
endpackage

// File: rtl/dpd_cfg_regs.sv
module dpd_cfg_regs
   import dpd_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter logic [NUM_WIN*ADDR_W-1:0] RST_BASE = '0,
   parameter logic [NUM_WIN*ADDR_W-1:0] RST_SIZE = '0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [CFG_IDX_W-1:0]             idx,
   input  logic [ADDR_W-1:0]                wdata,
   output logic [ADDR_W-1:0]                rdata,
   output logic [NUM_WIN-1:0][ADDR_W-1:0]   base_o,
   output logic [NUM_WIN-1:0][ADDR_W-1:0]   size_o,
   output logic [NUM_CHAN-1:0]              dev_o
);

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic [ADDR_W-1:0] base_r;
      logic [ADDR_W-1:0] size_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_r <= RST_BASE[w*ADDR_W +: ADDR_W];
            size_r <= RST_SIZE[w*ADDR_W +: ADDR_W];
         end else if (we && idx == CFG_IDX_W'(2*w)) begin
            base_r <= wdata;
         end else if (we && idx == CFG_IDX_W'(2*w+1)) begin
            size_r <= wdata;
         end
      end

      assign base_o[w] = base_r;
      assign size_o[w] = size_r;
   end

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_dev
      logic dev_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dev_r <= 1'b0;
         else if (we && idx == CFG_IDX_W'(CFG_DEV_IDX))
            dev_r <= wdata[c];
      end

      assign dev_o[c] = dev_r;
   end

   always_comb begin
      rdata = '0;
      for (int w = 0; w < NUM_WIN; w++) begin
         if (idx == CFG_IDX_W'(2*w))   rdata = base_o[w];
         if (idx == CFG_IDX_W'(2*w+1)) rdata = size_o[w];
      end
      if (idx == CFG_IDX_W'(CFG_DEV_IDX)) rdata = ADDR_W'(dev_o);
   end

endmodule

// File: rtl/dpd_win_match.sv
module dpd_win_match #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] size,
   output logic              hit,
   output logic [ADDR_W-1:0] offset
);
   // One guard bit keeps the window end from wrapping to low addresses
   logic [ADDR_W:0] end_x;

   assign end_x  = {1'b0, base} + {1'b0, size};
   assign hit    = (addr >= base) && ({1'b0, addr} < end_x);
   assign offset = addr - base;
endmodule

// File: rtl/dpd_prio_sel.sv
module dpd_prio_sel
   import dpd_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int BMI_SPLIT = 8
) (
   input  logic [NUM_WIN-1:0]             hit,
   input  logic [NUM_WIN-1:0][ADDR_W-1:0] offs,
   input  logic [NUM_CHAN-1:0]            dev,
   output win_kind_e                      kind,
   output logic                           sec,
   output logic [ADDR_W-1:0]              offset,
   output logic                           err,
   output logic [1:0]                     drive
);

   always_comb begin
      kind   = KIND_NONE;
      sec    = 1'b0;
      offset = '0;
      err    = 1'b1;
      // Walk from lowest priority upward so the first window wins
      for (int w = NUM_WIN - 1; w >= 0; w--) begin
         if (hit[w]) begin
            kind   = kind_of(w);
            offset = offs[w];
            err    = 1'b0;
            if (w == WIN_BMI)
               sec = (offs[w] >= ADDR_W'(BMI_SPLIT));
            else
               sec = chan_of(w);
         end
      end
      if (err)
         drive = 2'b00;
      else
         drive = {sec, (sec ? dev[1] : dev[0])};
   end

endmodule

// File: rtl/disk_port_decoder.sv
module disk_port_decoder
   import dpd_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int BMI_SPLIT = 8,
   parameter logic [NUM_WIN*ADDR_W-1:0] RST_BASE =
      {16'hF000, 16'h0374, 16'h0170, 16'h03F4, 16'h01F0},
   parameter logic [NUM_WIN*ADDR_W-1:0] RST_SIZE =
      {16'd16, 16'd4, 16'd8, 16'd4, 16'd8}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CFG_IDX_W-1:0] cfg_idx,
   input  logic [ADDR_W-1:0]    cfg_wdata,
   output logic [ADDR_W-1:0]    cfg_rdata,
   input  logic                 req_valid,
   input  logic [ADDR_W-1:0]    req_addr,
   output logic                 rsp_valid,
   output logic [1:0]           rsp_type,
   output logic                 rsp_secondary,
   output logic [ADDR_W-1:0]    rsp_offset,
   output logic                 rsp_err,
   output logic [1:0]           rsp_drive
);

   // Elaboration-time parameter checks
   if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_addr_w
      $error("disk_port_decoder: ADDR_W must lie in 4..32");
   end
   if (BMI_SPLIT < 1 || 64'(BMI_SPLIT) >= (64'd1 << ADDR_W)) begin : g_bad_split
      $error("disk_port_decoder: BMI_SPLIT must fit inside the address space");
   end

   logic [NUM_WIN-1:0][ADDR_W-1:0] base_w;
   logic [NUM_WIN-1:0][ADDR_W-1:0] size_w;
   logic [NUM_WIN-1:0][ADDR_W-1:0] offs_w;
   logic [NUM_WIN-1:0]             hit_w;
   logic [NUM_CHAN-1:0]            dev_w;

   win_kind_e         kind_d;
   logic              sec_d;
   logic [ADDR_W-1:0] offset_d;
   logic              err_d;
   logic [1:0]        drive_d;

   dpd_cfg_regs #(
      .ADDR_W  (ADDR_W),
      .RST_BASE(RST_BASE),
      .RST_SIZE(RST_SIZE)
   ) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .idx   (cfg_idx),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .base_o(base_w),
      .size_o(size_w),
      .dev_o (dev_w)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
      dpd_win_match #(.ADDR_W(ADDR_W)) u_match (
         .addr  (req_addr),
         .base  (base_w[w]),
         .size  (size_w[w]),
         .hit   (hit_w[w]),
         .offset(offs_w[w])
      );
   end

   dpd_prio_sel #(
      .ADDR_W   (ADDR_W),
      .BMI_SPLIT(BMI_SPLIT)
   ) u_sel (
      .hit   (hit_w),
      .offs  (offs_w),
      .dev   (dev_w),
      .kind  (kind_d),
      .sec   (sec_d),
      .offset(offset_d),
      .err   (err_d),
      .drive (drive_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_type      <= KIND_NONE;
         rsp_secondary <= 1'b0;
         rsp_offset    <= '0;
         rsp_err       <= 1'b0;
         rsp_drive     <= 2'b00;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_type      <= kind_d;
            rsp_secondary <= sec_d;
            rsp_offset    <= offset_d;
            rsp_err       <= err_d;
            rsp_drive     <= drive_d;
         end
      end
   end

endmodule

// File: rtl/dpd_chk.sv
module dpd_chk
   import dpd_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int BMI_SPLIT = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [CFG_IDX_W-1:0] cfg_idx,
   input logic [ADDR_W-1:0]    cfg_rdata,
   input logic                 req_valid,
   input logic [ADDR_W-1:0]    req_addr,
   input logic                 rsp_valid,
   input logic [1:0]           rsp_type,
   input logic                 rsp_secondary,
   input logic [ADDR_W-1:0]    rsp_offset,
   input logic                 rsp_err,
   input logic [1:0]           rsp_drive
);

   p_reset_quiet_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> !rsp_valid);

   p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   p_hit_typed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_err) |-> (rsp_type != 2'd0));

   p_miss_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |->
         (rsp_type == 2'd0 && rsp_drive == 2'd0 && rsp_offset == '0 && !rsp_secondary));

   p_drive_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_err) |-> (rsp_drive[1] == rsp_secondary));

   p_bmi_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_type == 2'd3) |->
         (rsp_secondary == (rsp_offset >= ADDR_W'(BMI_SPLIT))));

   p_offset_in_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_err) |-> (rsp_offset <= $past(req_addr)));

   p_unused_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_idx > CFG_IDX_W'(CFG_DEV_IDX)) |-> (cfg_rdata == '0));

endmodule

bind disk_port_decoder dpd_chk #(.ADDR_W(ADDR_W), .BMI_SPLIT(BMI_SPLIT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_idx      (cfg_idx),
   .cfg_rdata    (cfg_rdata),
   .req_valid    (req_valid),
   .req_addr     (req_addr),
   .rsp_valid    (rsp_valid),
   .rsp_type     (rsp_type),
   .rsp_secondary(rsp_secondary),
   .rsp_offset   (rsp_offset),
   .rsp_err      (rsp_err),
   .rsp_drive    (rsp_drive)
);

// File: tb/sim_disk_port_decoder.sv
`timescale 1ns/1ps
module sim_disk_port_decoder;

   localparam int AW = 16;
   localparam int SPLIT = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [3:0]    cfg_idx = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic [AW-1:0] cfg_rdata;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid;
   logic [1:0]    rsp_type;
   logic          rsp_secondary;
   logic [AW-1:0] rsp_offset;
   logic          rsp_err;
   logic [1:0]    rsp_drive;

   always #4 clk = ~clk;

   disk_port_decoder u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
      .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_type(rsp_type),
      .rsp_secondary(rsp_secondary), .rsp_offset(rsp_offset),
      .rsp_err(rsp_err), .rsp_drive(rsp_drive)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // Reference model state, written only by the bench's config tasks
   logic [AW-1:0] mbase [5];
   logic [AW-1:0] msize [5];
   logic [1:0]    mdev;

   // Expected item: {err, type[1:0], secondary, drive[1:0], offset[15:0]}
   logic [21:0] expq [$];
   string       tagq [$];

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [21:0] model(input logic [AW-1:0] a);
      logic [1:0] ty;
      logic       sec;
      logic [AW-1:0] off;
      int hitw;
      hitw = -1;
      for (int w = 0; w < 5; w++) begin
         if (hitw < 0 && ({1'b0, a} >= {1'b0, mbase[w]}) &&
             ({1'b0, a} < ({1'b0, mbase[w]} + {1'b0, msize[w]})))
            hitw = w;
      end
      if (hitw < 0) return 22'h200000;
      off = a - mbase[hitw];
      case (hitw)
         0: begin ty = 2'd1; sec = 1'b0; end
         1: begin ty = 2'd2; sec = 1'b0; end
         2: begin ty = 2'd1; sec = 1'b1; end
         3: begin ty = 2'd2; sec = 1'b1; end
         default: begin ty = 2'd3; sec = (off >= AW'(SPLIT)); end
      endcase
      return {1'b0, ty, sec, sec, (sec ? mdev[1] : mdev[0]), off};
   endfunction

   task automatic send(input logic [AW-1:0] a, input string tag);
      req_valid = 1'b1;
      req_addr  = a;
      expq.push_back(model(a));
      tagq.push_back(tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic cfg_wr(input int idx, input logic [AW-1:0] d);
      cfg_we    = 1'b1;
      cfg_idx   = 4'(idx);
      cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (idx < 10) begin
         if (idx % 2 == 0) mbase[idx/2] = d;
         else              msize[idx/2] = d;
      end else if (idx == 10) begin
         mdev = d[1:0];
      end
   endtask

   task automatic cfg_rd(input int idx, input logic [AW-1:0] exp, input string tag);
      cfg_idx = 4'(idx);
      #1;
      check(cfg_rdata === exp, tag, 32'(cfg_rdata), 32'(exp));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // Monitor: compare each result against the scoreboard
   always @(negedge clk) begin
      if (rst_n && !done && rsp_valid) begin
         if (expq.size() == 0) begin
            check(1'b0, "R10 unexpected result", 32'(rsp_offset), 32'h0);
         end else begin
            logic [21:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check({rsp_err, rsp_type, rsp_secondary, rsp_drive, rsp_offset} === e, t,
                  32'({rsp_err, rsp_type, rsp_secondary, rsp_drive, rsp_offset}), 32'(e));
         end
      end
   end

   initial begin
      #(8 * 20000);
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      finish_run();
   end

   initial begin
      mbase[0] = 16'h01F0; msize[0] = 16'd8;
      mbase[1] = 16'h03F4; msize[1] = 16'd4;
      mbase[2] = 16'h0170; msize[2] = 16'd8;
      mbase[3] = 16'h0374; msize[3] = 16'd4;
      mbase[4] = 16'hF000; msize[4] = 16'd16;
      mdev = 2'b00;

      repeat (3) @(negedge clk);
      check(rsp_valid === 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid === 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);
      for (int i = 0; i < 10; i++)
         cfg_rd(i, (i % 2 == 0) ? mbase[i/2] : msize[i/2], "R1 R9 default readback");
      cfg_rd(10, 16'h0000, "R1 device-select default");

      // R2 R3 R4: edges of each per-channel window
      send(16'h01F0, "R2 R3 R4 primary command base");
      send(16'h01F7, "R2 R4 primary command last byte");
      send(16'h01F8, "R2 R6 one past primary command");
      send(16'h01EF, "R2 R6 below primary command");
      send(16'h03F4, "R3 primary control base");
      send(16'h03F7, "R3 R4 primary control last byte");
      send(16'h0170, "R3 secondary command");
      send(16'h0377, "R3 R4 secondary control last byte");
      send(16'h0378, "R6 past secondary control");
      // R5: bus-master split
      send(16'hF000, "R5 bus-master offset 0");
      send(16'hF007, "R5 bus-master offset 7 primary");
      send(16'hF008, "R5 bus-master offset 8 secondary");
      send(16'hF00F, "R5 bus-master offset 15");
      send(16'hF010, "R6 past bus-master");
      @(negedge clk);
      check(rsp_valid === 1'b0, "R10 idle gives no result", 32'(rsp_valid), 32'h0);

      // R8: device-select bits per channel
      cfg_wr(10, 16'h0003);
      cfg_rd(10, 16'h0003, "R9 R8 device-select readback");
      send(16'h01F2, "R8 primary drive 1");
      send(16'h0172, "R8 secondary drive 3");
      send(16'hF00A, "R8 R5 bus-master secondary drive 3");
      cfg_wr(10, 16'h0002);
      send(16'h03F5, "R8 primary drive 0");
      send(16'h0375, "R8 secondary drive 3 with bit1");
      cfg_wr(10, 16'h0001);
      send(16'h0171, "R8 secondary drive 2");
      send(16'hF001, "R8 bus-master primary drive 1");

      // R9: unused index ignored
      cfg_wr(12, 16'hBEEF);
      cfg_rd(12, 16'h0000, "R9 unused index reads 0");
      cfg_rd(0, 16'h01F0, "R9 base unchanged by unused write");
      cfg_rd(10, 16'h0001, "R9 device-select unchanged by unused write");
      send(16'h01F3, "R9 decode unchanged after unused write");

      // R7: overlap priority, then R11 disabled window
      cfg_wr(4, 16'h01F0);
      cfg_rd(4, 16'h01F0, "R9 secondary command base written");
      send(16'h01F4, "R7 overlap resolves to primary command");
      cfg_wr(1, 16'h0000);
      send(16'h01F4, "R11 size 0 disables primary command");
      send(16'h01F0, "R11 R7 falls through to secondary command");

      // R11: window reaching the top of the address space
      cfg_wr(8, 16'hFFF8);
      send(16'hFFF8, "R11 top window base");
      send(16'hFFFF, "R11 top window last address");
      send(16'h0000, "R11 no wrap to address 0");
      send(16'h0007, "R11 no wrap to address 7");
      send(16'hF008, "R2 old bus-master location misses");

      // R10: ordering of back-to-back requests
      cfg_wr(10, 16'h0000);
      send(16'h03F6, "R10 back-to-back 1");
      send(16'h0376, "R10 back-to-back 2");
      send(16'hFFFA, "R10 back-to-back 3");

      repeat (3) @(negedge clk);
      check(expq.size() == 0, "R10 every request answered",
            32'(expq.size()), 32'h0);
      finish_run();
   end

endmodule